// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a small table of per-branch outcome histories. Each history is a shift register that holds the most recent outcomes of the branches that map to its slot. The history chosen for a branch selects one 2-bit saturating counter in a shared pattern table, and the upper bit of that counter is the prediction. A branch that follows a regular rhythm, such as taken on every third execution, therefore gets a counter for each point in its rhythm and is predicted without error once the counters have trained.

The fetch side presents a PC on the lookup port and receives the prediction in the same cycle. The history and counter behind the prediction are returned with it. The execute side reports each resolved branch on the resolve port with its PC and actual outcome. That report trains the counter chosen by the branch's history as it stood before the report, and then shifts the outcome into the history. Resolve updates take effect at the next clock edge.

Top module: `twolvl_bpred`

## Requirements
- R1: After reset every history slot holds 0 and every pattern counter holds 1 (weakly not taken), so every lookup returns history 0, counter 1 and a not-taken prediction.
- R2: A lookup selects history slot PC[5:2] (16 slots). It returns that slot's history on lk_hist, the pattern counter indexed by that history on lk_ctr, and lk_taken = 1 exactly when the counter is 2 or 3. Counter codes are 0 strongly not taken, 1 weakly not taken, 2 weakly taken and 3 strongly taken.
- R3: A taken resolve increments the selected counter by one, and a counter at 3 stays at 3.
- R4: A not-taken resolve decrements the selected counter by one, and a counter at 0 stays at 0.
- R5: The counter trained by a resolve is the one indexed by the slot's history from before that resolve shifts it.
- R6: A resolve shifts its outcome into bit 0 of the slot's history (1 for taken, 0 for not taken) and drops the oldest bit, bit 3.
- R7: A resolve changes only history slot rs_pc[5:2]. PCs that differ only outside bits 5:2 share that slot.
- R8: While rs_valid is low, no history or counter changes, whatever rs_pc and rs_taken carry.
- R9: A lookup in the same cycle as a resolve of the same slot returns the state from before that resolve. The update is visible from the next cycle.
- R10: A branch that repeats the outcome sequence not taken, not taken, taken is predicted correctly on every execution once it has trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | 4 | History of the looked-up slot |
| lk_ctr | output | 2 | Pattern counter selected by lk_hist |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
A lookup and a resolve can arrive in the same cycle and hit the same history slot. The same-slot case is provoked directly, and the 3-cycle rhythm test also does it on every execution. The monitor expects the pre-update history and counter in that cycle and the trained values in the following one. Aliased PCs and resolves with rs_valid low sit beside those collisions, and each is judged against a reference table of histories and counters that the bench updates from the requirements alone.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WNT = 2'd1;
  localparam ctr_t CTR_STK = 2'd3;

  // one saturating step toward taken (up=1) or not taken (up=0)
  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t res;
    if (up) res = (cur == CTR_STK) ? CTR_STK : ctr_t'(cur + 2'd1);
    else    res = (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
    return res;
  endfunction

endpackage

// File: rtl/bpred_hist_table.sv
module bpred_hist_table #(
  parameter int HIST_W  = 4,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_old_hist
);

  logic [HIST_W-1:0] hist_q   [ENTRIES];
  logic [HIST_W-1:0] hist_nxt [ENTRIES];
  logic [ENTRIES-1:0] ent_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);

    always_comb begin
      ent_en[g]   = wr_en && (wr_idx == SLOT);
      hist_nxt[g] = {hist_q[g][HIST_W-2:0], wr_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hist_q[g] <= '0;
      else if (ent_en[g]) hist_q[g] <= hist_nxt[g];
    end
  end

  always_comb begin
    rd_hist     = hist_q[rd_idx];
    wr_old_hist = hist_q[wr_idx];
  end

endmodule

// File: rtl/bpred_pattern_table.sv
module bpred_pattern_table
  import bpred_pkg::*;
#(
  parameter int HIST_W  = 4,
  localparam int ENTRIES = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr_t              rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);

  ctr_t ctr_q   [ENTRIES];
  ctr_t ctr_nxt [ENTRIES];
  logic [ENTRIES-1:0] ent_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    localparam logic [HIST_W-1:0] SLOT = HIST_W'(g);

    always_comb begin
      ent_en[g]  = wr_en && (wr_idx == SLOT);
      ctr_nxt[g] = ctr_step(ctr_q[g], wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctr_q[g] <= CTR_WNT;
      else if (ent_en[g]) ctr_q[g] <= ctr_nxt[g];
    end
  end

  always_comb rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/twolvl_bpred.sv
module twolvl_bpred #(
  parameter int PC_W        = 32,
  parameter int HIST_W      = 4,
  parameter int BHT_ENTRIES = 16,
  parameter int IDX_LSB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  output logic [1:0]        lk_ctr,
  input  logic              rs_valid,
  input  logic [PC_W-1:0]   rs_pc,
  input  logic              rs_taken
);

  localparam int IDX_W = $clog2(BHT_ENTRIES);

  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  rs_idx;
  logic [HIST_W-1:0] rs_hist;
  bpred_pkg::ctr_t   lk_ctr_w;

  always_comb begin
    lk_idx = lk_pc[IDX_LSB +: IDX_W];
    rs_idx = rs_pc[IDX_LSB +: IDX_W];
  end

  bpred_hist_table #(
    .HIST_W  (HIST_W),
    .ENTRIES (BHT_ENTRIES)
  ) u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (lk_idx),
    .rd_hist     (lk_hist),
    .wr_en       (rs_valid),
    .wr_idx      (rs_idx),
    .wr_bit      (rs_taken),
    .wr_old_hist (rs_hist)
  );

  bpred_pattern_table #(
    .HIST_W (HIST_W)
  ) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_hist),
    .rd_ctr   (lk_ctr_w),
    .wr_en    (rs_valid),
    .wr_idx   (rs_hist),
    .wr_taken (rs_taken)
  );

  always_comb begin
    lk_ctr   = lk_ctr_w;
    lk_taken = lk_ctr_w[1];
  end

endmodule

// File: rtl/bpred_check.sv
module bpred_check #(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 4,
  parameter int IDX_W   = 4,
  parameter int IDX_LSB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   lk_pc,
  input logic [HIST_W-1:0] lk_hist,
  input logic [1:0]        lk_ctr,
  input logic              rs_valid,
  input logic [PC_W-1:0]   rs_pc,
  input logic              rs_taken
);

  logic [IDX_W-1:0] lk_idx;
  logic             same_slot;

  always_comb begin
    lk_idx    = lk_pc[IDX_LSB +: IDX_W];
    same_slot = lk_idx == rs_pc[IDX_LSB +: IDX_W];
  end

  // R8: with no resolve, a steady lookup sees steady state
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> (!$stable(lk_pc) || ($stable(lk_hist) && $stable(lk_ctr))));

  // R6: outcome enters bit 0, oldest bit leaves
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && same_slot) |=>
      ((lk_idx != $past(lk_idx)) ||
       (lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(rs_taken)})));

  // R3: all-taken history keeps selecting the same counter, which climbs and clamps
  assert_ctr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && same_slot && rs_taken && (lk_hist == {HIST_W{1'b1}})) |=>
      ((lk_idx != $past(lk_idx)) ||
       (lk_ctr == (($past(lk_ctr) == 2'd3) ? 2'd3 : 2'($past(lk_ctr) + 2'd1)))));

  // R4: all-not-taken history keeps selecting counter 0, which falls and clamps
  assert_ctr_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && same_slot && !rs_taken && (lk_hist == '0)) |=>
      ((lk_idx != $past(lk_idx)) ||
       (lk_ctr == (($past(lk_ctr) == 2'd0) ? 2'd0 : 2'($past(lk_ctr) - 2'd1)))));

endmodule

bind twolvl_bpred bpred_check #(
  .PC_W    (PC_W),
  .HIST_W  (HIST_W),
  .IDX_W   (IDX_W),
  .IDX_LSB (IDX_LSB)
) u_bpred_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_pc    (lk_pc),
  .lk_hist  (lk_hist),
  .lk_ctr   (lk_ctr),
  .rs_valid (rs_valid),
  .rs_pc    (rs_pc),
  .rs_taken (rs_taken)
);

// File: tb/twolvl_bpred_bench.sv
`timescale 1ns/1ps
module twolvl_bpred_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic [3:0]  lk_hist;
  logic [1:0]  lk_ctr;
  logic        rs_valid;
  logic [31:0] rs_pc;
  logic        rs_taken;

  always #2.5 clk = ~clk;

  twolvl_bpred u_twolvl_bpred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .lk_ctr(lk_ctr), .rs_valid(rs_valid),
    .rs_pc(rs_pc), .rs_taken(rs_taken)
  );

  typedef struct {
    logic       t;
    logic [3:0] h;
    logic [1:0] c;
    string      tag;
  } exp_t;

  exp_t q[$];
  event mon_ev;
  int   n_chk = 0;
  int   n_bad = 0;

  // reference tables from the requirements
  logic [3:0] hist_m [16];
  logic [1:0] ctr_m  [16];

  task automatic chk(input logic ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor: pops one expected lookup result per trigger
  initial begin
    forever begin
      @(mon_ev);
      if (q.size() == 0) begin
        chk(1'b0, "monitor", "no expected item queued");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(lk_taken === e.t && lk_hist === e.h && lk_ctr === e.c, e.tag,
            $sformatf("actual t=%0b h=%b c=%0d expected t=%0b h=%b c=%0d",
                      lk_taken, lk_hist, lk_ctr, e.t, e.h, e.c));
      end
    end
  end

  // driver: one cycle of lookup plus optional resolve
  task automatic step(input logic [31:0] lpc, input logic rv,
                      input logic [31:0] rpc, input logic rt, input string tag);
    exp_t e;
    logic [3:0] h;
    @(negedge clk);
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt;
    e.h = hist_m[lpc[5:2]];
    e.c = ctr_m[e.h];
    e.t = e.c[1];
    e.tag = tag;
    q.push_back(e);
    #1 -> mon_ev;
    if (rv) begin
      h = hist_m[rpc[5:2]];
      if (rt) ctr_m[h] = (ctr_m[h] == 2'd3) ? 2'd3 : ctr_m[h] + 2'd1;
      else    ctr_m[h] = (ctr_m[h] == 2'd0) ? 2'd0 : ctr_m[h] - 2'd1;
      hist_m[rpc[5:2]] = {h[2:0], rt};
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", "run did not finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin hist_m[i] = 4'd0; ctr_m[i] = 2'd1; end
    rst_n = 1'b1; lk_pc = '0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state on every slot
    for (int i = 0; i < 16; i++) step(32'h100 + 32'(i*4), 1'b0, '0, 1'b0, "R1");

    // R3 R5 R6: slot 1 taken repeatedly, climbing to all-ones and saturating
    for (int i = 0; i < 8; i++) step(32'h44, 1'b1, 32'h44, 1'b1, "R3");
    step(32'h44, 1'b0, '0, 1'b0, "R3");
    chk(lk_hist === 4'b1111 && lk_ctr === 2'd3, "R3",
        $sformatf("actual h=%b c=%0d expected h=1111 c=3", lk_hist, lk_ctr));

    // R4 R6: slot 5 not taken repeatedly, counter 0 falls and clamps
    for (int i = 0; i < 6; i++) step(32'h54, 1'b1, 32'h54, 1'b0, "R4");
    step(32'h54, 1'b0, '0, 1'b0, "R4");
    chk(lk_hist === 4'b0000 && lk_ctr === 2'd0 && lk_taken === 1'b0, "R4",
        $sformatf("actual h=%b c=%0d expected h=0000 c=0", lk_hist, lk_ctr));

    // R5 R6: mixed outcomes on slot 2
    step(32'h48, 1'b1, 32'h48, 1'b1, "R5");
    step(32'h48, 1'b1, 32'h48, 1'b0, "R5");
    step(32'h48, 1'b1, 32'h48, 1'b1, "R6");
    step(32'h48, 1'b0, '0, 1'b0, "R6");
    chk(lk_hist === 4'b0101, "R6", $sformatf("actual h=%b expected h=0101", lk_hist));

    // R8: resolve data toggles with rs_valid low
    for (int i = 0; i < 4; i++) step(32'h48, 1'b0, 32'h48, i[0], "R8");

    // R7: aliased PC trains slot 3, neighbours untouched
    step(32'h4C, 1'b1, 32'h84C, 1'b1, "R7");
    step(32'h4C, 1'b0, '0, 1'b0, "R7");
    chk(lk_hist === 4'b0001, "R7", $sformatf("actual h=%b expected h=0001", lk_hist));
    step(32'h50, 1'b0, '0, 1'b0, "R7");
    step(32'h40, 1'b0, '0, 1'b0, "R7");

    // R9: same-cycle lookup sees pre-update state, next cycle sees update
    step(32'h58, 1'b1, 32'h58, 1'b1, "R9");
    chk(lk_hist === 4'b0000, "R9", $sformatf("actual h=%b expected h=0000", lk_hist));
    step(32'h58, 1'b0, '0, 1'b0, "R9");
    chk(lk_hist === 4'b0001, "R9", $sformatf("actual h=%b expected h=0001", lk_hist));

    // R10 R2: rhythm 0,0,1 on slot 10, lookup and resolve together
    for (int i = 0; i < 45; i++) begin
      logic o;
      o = (i % 3 == 2);
      step(32'h68, 1'b1, 32'h68, o, "R2");
      if (i >= 30)
        chk(lk_taken === o, "R10",
            $sformatf("iter %0d actual pred=%0b expected %0b", i, lk_taken, o));
    end

    @(negedge clk);
    rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule